// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a down-counting supervision timer that runs on the system clock. Software first writes a start count and then chooses what expiry should trigger: a system reset request, a nonmaskable interrupt or an ordinary interrupt. Software then sets the enable bit. While the timer runs, software must issue a reload command at regular intervals. The reload puts the programmed count back into the counter. If the counter reaches zero and sits there for one enabled clock, the timer expires and raises the chosen action once.

A reset-cause flag records each expiry that asked for a reset. Only the block's own synchronous reset clears it, which is meant to be the power-on reset, or a write-one-to-clear from software. The reset request that the watchdog itself produces goes to the system and does not clear the flag, so software can read it after the system restarts. Access uses a single-cycle write strobe, a 2-bit register address and a read bus that is decoded without a register.

Top module: `wdog_timer`

## Requirements
- R1: After reset, all three action outputs are low and every register address reads zero.
- R2: A write to address 0 stores the start count and also places that value in the counter at the same clock edge. Address 0 reads back the stored value, and address 2 reads the live count.
- R3: While the enable bit is set (address 1, bit 0), the count drops by exactly one on every clock until it reaches zero. While the bit is clear, the count holds its value.
- R4: The timer expires on the first enabled clock edge at which the count is already zero. The action output rises after that edge. After this, the count stays at zero and no further expiry happens until software writes address 0 or address 2.
- R5: Any write to address 2 is a reload. It copies the stored start count into the counter and leaves the start count and the control field unchanged. A reload that lands on the same edge as a pending expiry cancels that expiry.
- R6: With action code 1 (address 1, bits 2:1), an expiry drives the nonmaskable interrupt output high for exactly one clock.
- R7: With action code 2 or 3, an expiry drives the general interrupt output high for exactly one clock.
- R8: With action code 0, an expiry holds the reset request output high for exactly RST_HOLD clocks (16 by default).
- R9: The reset-cause flag (address 3, bit 0) becomes set on each expiry with action code 0. An expiry with an interrupt action does not set it. Only the block reset or a write to address 3 with bit 0 equal to 1 clears it; writing 0 to that bit leaves it unchanged.
- R10: While the enable bit is clear, no action output is asserted, whatever the count.
- R11: At most one action output is high at any time. While a reset request is being held, interrupt expiries are suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| addr | input | 2 | Register address: 0 start count, 1 control, 2 reload / live count, 3 reset-cause flag |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, no register stage |
| wd_rst_req | output | 1 | System reset request, held for RST_HOLD clocks |
| wd_nmi | output | 1 | Nonmaskable interrupt pulse |
| wd_irq | output | 1 | General interrupt pulse |

## Verification
The assertions hold on every cycle. They check that at most one action output is high, that each interrupt pulse lasts only one clock, and that an idle enabled counter steps down by one while a disabled counter stays put. They also check that the reset-cause flag stays set until it is cleared, and that a reset request never starts unless the flag is set. The bench scenarios cover the timing that depends on how the stimulus is ordered: the exact clock on which expiry fires for a given start count, a reload that arrives on the very edge of expiry, the sixteen-clock reset hold, and the rule that expiry fires only once. The scenarios also cover write-one-to-clear on the flag and the fact that interrupt expiries leave the flag untouched.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ACT_RESET = 2'd0,
        ACT_NMI   = 2'd1,
        ACT_IRQ   = 2'd2,
        ACT_IRQ_B = 2'd3
    } wd_action_e;

    typedef enum logic [1:0] {
        RA_START  = 2'd0,
        RA_CTRL   = 2'd1,
        RA_RELOAD = 2'd2,
        RA_CAUSE  = 2'd3
    } wd_addr_e;

    typedef struct packed {
        wd_action_e act;
        logic       en;
    } wd_ctrl_t;

    localparam int CTRL_W = $bits(wd_ctrl_t);

    function automatic logic is_irq(wd_action_e a);
        return (a == ACT_IRQ) || (a == ACT_IRQ_B);
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             cause_set,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] start_q,
    output wd_ctrl_t         ctrl_q,
    output logic             cause_q,
    output logic             start_wr,
    output logic             reload_wr,
    output logic [CNT_W-1:0] rdata
);

    localparam int PAD_W = CNT_W - CTRL_W;

    wd_addr_e sel;
    assign sel       = wd_addr_e'(addr);
    assign start_wr  = wr_en && (sel == RA_START);
    assign reload_wr = wr_en && (sel == RA_RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            ctrl_q  <= '0;
            cause_q <= 1'b0;
        end else begin
            if (start_wr)
                start_q <= wdata;
            if (wr_en && sel == RA_CTRL)
                ctrl_q <= wd_ctrl_t'(wdata[CTRL_W-1:0]);
            if (cause_set)
                cause_q <= 1'b1;
            else if (wr_en && sel == RA_CAUSE && wdata[0])
                cause_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            RA_START:  rdata = start_q;
            RA_CTRL:   rdata = {{PAD_W{1'b0}}, ctrl_q};
            RA_RELOAD: rdata = cnt;
            RA_CAUSE:  rdata = {{(CNT_W-1){1'b0}}, cause_q};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start_wr,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    logic spent_q;
    logic at_zero;

    assign at_zero = (cnt_q == '0);
    assign expire  = en && at_zero && !spent_q && !start_wr && !reload_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            spent_q <= 1'b0;
        end else if (start_wr) begin
            cnt_q   <= wdata;
            spent_q <= 1'b0;
        end else if (reload_wr) begin
            cnt_q   <= start_val;
            spent_q <= 1'b0;
        end else if (en) begin
            if (!at_zero)
                cnt_q <= cnt_q - 1'b1;
            else
                spent_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wdog_action.sv
module wdog_action
    import wdog_pkg::*;
#(
    parameter int RST_HOLD = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  wd_action_e act,
    output logic       cause_set,
    output logic       rst_req,
    output logic       nmi,
    output logic       irq
);

    localparam int HOLD_W = $clog2(RST_HOLD + 1);

    logic [HOLD_W-1:0] hold_q;
    logic              holding;

    assign holding   = (hold_q != '0);
    assign cause_set = expire && (act == ACT_RESET);
    assign rst_req   = holding;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            nmi    <= 1'b0;
            irq    <= 1'b0;
        end else begin
            nmi <= expire && !holding && (act == ACT_NMI);
            irq <= expire && !holding && is_irq(act);
            if (cause_set)
                hold_q <= HOLD_W'(RST_HOLD);
            else if (holding)
                hold_q <= hold_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int RST_HOLD = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             wd_rst_req,
    output logic             wd_nmi,
    output logic             wd_irq
);

    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] cnt_q;
    wd_ctrl_t         ctrl_q;
    logic             en_q;
    logic             status_q;
    logic             start_wr;
    logic             reload_wr;
    logic             expire;
    logic             cause_set;

    assign en_q = ctrl_q.en;

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cause_set (cause_set),
        .cnt       (cnt_q),
        .start_q   (start_q),
        .ctrl_q    (ctrl_q),
        .cause_q   (status_q),
        .start_wr  (start_wr),
        .reload_wr (reload_wr),
        .rdata     (rdata)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .en        (en_q),
        .start_wr  (start_wr),
        .reload_wr (reload_wr),
        .wdata     (wdata),
        .start_val (start_q),
        .cnt_q     (cnt_q),
        .expire    (expire)
    );

    wdog_action #(.RST_HOLD(RST_HOLD)) u_action (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .act       (ctrl_q.act),
        .cause_set (cause_set),
        .rst_req   (wd_rst_req),
        .nmi       (wd_nmi),
        .irq       (wd_irq)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic             en_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             status_q,
    input logic             wd_rst_req,
    input logic             wd_nmi,
    input logic             wd_irq
);

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wd_rst_req, wd_nmi, wd_irq})); // R11

    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wd_nmi |=> !wd_nmi); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wd_irq |=> !wd_irq); // R7

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (en_q && cnt_q != '0 && !wr_en) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !wr_en) |=> $stable(cnt_q)); // R3

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_q && !(wr_en && addr == 2'd3 && wdata[0])) |=> status_q); // R9

    AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_rst_req) |-> status_q); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !wd_rst_req) |=> (!wd_nmi && !wd_irq)); // R10

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .en_q       (en_q),
    .cnt_q      (cnt_q),
    .status_q   (status_q),
    .wd_rst_req (wd_rst_req),
    .wd_nmi     (wd_nmi),
    .wd_irq     (wd_irq)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

    localparam int CNT_W = 32;
    localparam int HOLD  = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       addr = 2'd0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic             wd_rst_req, wd_nmi, wd_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wdog_timer #(.CNT_W(CNT_W), .RST_HOLD(HOLD)) u_wdog_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wd_rst_req(wd_rst_req), .wd_nmi(wd_nmi), .wd_irq(wd_irq)
    );

    // expected {rst_req, nmi, irq} for the first cycle after expiry
    function automatic logic [2:0] exp_outs(int act);
        case (act)
            0: return 3'b100;
            1: return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] ctrl_word(int act, bit en);
        return CNT_W'((act << 1) | int'(en));
    endfunction

    task automatic check(bit ok, string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(logic [1:0] a, logic [CNT_W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [CNT_W-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [2:0] outs();
        return {wd_rst_req, wd_nmi, wd_irq};
    endfunction

    // waits for expiry of count n (already in the counter) and checks the action
    task automatic expect_expiry(int n, int act, string tag);
        logic [CNT_W-1:0] v;
        idle(n);
        rd(2'd2, v);
        check(v == 0, {tag, " R3 count at zero"}, v, 0);
        check(outs() == 3'b000, {tag, " R4 no early action"}, CNT_W'(outs()), 0);
        @(negedge clk);
        check(outs() == exp_outs(act), {tag, " R4 action after expiry"},
              CNT_W'(outs()), CNT_W'(exp_outs(act)));
        if (act == 0) begin
            for (int i = 1; i < HOLD; i++) @(negedge clk);
            check(wd_rst_req, {tag, " R8 request held to last cycle"}, CNT_W'(wd_rst_req), 1);
            @(negedge clk);
            check(!wd_rst_req, {tag, " R8 request drops after hold"}, CNT_W'(wd_rst_req), 0);
        end else begin
            @(negedge clk);
            check(outs() == 3'b000, {tag, act == 1 ? " R6 single pulse" : " R7 single pulse"},
                  CNT_W'(outs()), 0);
        end
        rd(2'd3, v);
        check(v == CNT_W'(act == 0), {tag, " R9 cause flag"}, v, CNT_W'(act == 0));
    endtask

    initial begin
        logic [CNT_W-1:0] v;
        void'($urandom(32'd2024));
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(outs() == 3'b000, "R1 outputs low", CNT_W'(outs()), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R1 register reads zero", v, 0);
        end

        // R2 load and readback
        wr(2'd0, 32'hDEAD_BEEF);
        rd(2'd0, v); check(v == 32'hDEAD_BEEF, "R2 start readback", v, 32'hDEAD_BEEF);
        rd(2'd2, v); check(v == 32'hDEAD_BEEF, "R2 live count loaded", v, 32'hDEAD_BEEF);

        // R10 disabled with zero count: nothing fires, count holds
        wr(2'd0, 0);
        wr(2'd1, ctrl_word(1, 0));
        idle(6);
        check(outs() == 3'b000, "R10 disabled stays quiet", CNT_W'(outs()), 0);
        wr(2'd1, ctrl_word(1, 1));
        expect_expiry(0, 1, "dir-nmi0");

        // R4 no repeat after expiry
        idle(20);
        rd(2'd2, v);
        check(v == 0 && outs() == 3'b000, "R4 no second expiry", CNT_W'(outs()), 0);

        // R3 disable mid-count holds
        wr(2'd1, ctrl_word(2, 0));
        wr(2'd0, 10);
        wr(2'd1, ctrl_word(2, 1));
        idle(3);
        wr(2'd1, ctrl_word(2, 0));
        rd(2'd2, v); check(v == 6, "R3 count after disable", v, 6);
        idle(5);
        rd(2'd2, v); check(v == 6, "R3 disabled count holds", v, 6);

        // R5 reload on the expiry edge cancels it and keeps config
        wr(2'd0, 4);
        wr(2'd1, ctrl_word(3, 1));
        idle(4);
        rd(2'd2, v); check(v == 0, "R5 count reached zero", v, 0);
        wr(2'd2, 32'h1234);
        check(outs() == 3'b000, "R5 reload cancels expiry", CNT_W'(outs()), 0);
        rd(2'd2, v); check(v == 4, "R5 reload restores start", v, 4);
        rd(2'd0, v); check(v == 4, "R5 start unchanged", v, 4);
        rd(2'd1, v); check(v == ctrl_word(3, 1), "R5 control unchanged", v, ctrl_word(3, 1));
        expect_expiry(4, 3, "dir-irq3");

        // R8/R9 reset action, then write-zero and write-one to the flag
        wr(2'd1, ctrl_word(0, 0));
        wr(2'd0, 7);
        wr(2'd1, ctrl_word(0, 1));
        expect_expiry(7, 0, "dir-rst");
        wr(2'd1, ctrl_word(0, 0));
        wr(2'd3, 0);
        rd(2'd3, v); check(v == 1, "R9 write zero keeps flag", v, 1);
        wr(2'd3, 1);
        rd(2'd3, v); check(v == 0, "R9 write one clears flag", v, 0);

        // R11 interrupt expiry during a reset hold is suppressed
        wr(2'd0, 0);
        wr(2'd1, ctrl_word(0, 1));
        @(negedge clk);
        check(wd_rst_req, "R11 hold started", CNT_W'(wd_rst_req), 1);
        wr(2'd1, ctrl_word(1, 1));
        wr(2'd2, 0);
        @(negedge clk);
        check(outs() == 3'b100, "R11 interrupt masked during hold", CNT_W'(outs()), 3'b100);
        wr(2'd1, ctrl_word(1, 0));
        idle(HOLD);
        wr(2'd3, 1);

        // random trials
        for (int t = 0; t < 30; t++) begin
            int n, act, k;
            string tag;
            n   = $urandom_range(0, 40);
            act = $urandom_range(0, 3);
            tag = $sformatf("rand%0d", t);
            wr(2'd1, ctrl_word(act, 0));
            wr(2'd0, CNT_W'(n));
            wr(2'd1, ctrl_word(act, 1));
            if (n > 2 && $urandom_range(0, 1) == 1) begin
                k = $urandom_range(0, n - 1);
                idle(k);
                rd(2'd2, v);
                check(v == CNT_W'(n - k), {tag, " R3 mid count"}, v, CNT_W'(n - k));
                wr(2'd2, 0);
                rd(2'd2, v);
                check(v == CNT_W'(n), {tag, " R5 kick restores"}, v, CNT_W'(n));
            end
            expect_expiry(n, act, tag);
            wr(2'd1, ctrl_word(act, 0));
            wr(2'd3, 1);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule